// File: doc/BRIEF.md
# Command-Controlled Serial Receiver with Address Filtering

This block receives asynchronous serial characters from a single line and stores them in a small queue that the host reads. The host drives it through an 8-bit command code and a one-cycle strobe. One command starts reception, one stops it, and a third arms an address hunt. A free-running sample-enable at sixteen times the bit rate paces the receiver. Each received character goes into the queue together with the extra flag bit that follows its data.

The address hunt serves multi-drop links. While the hunt is armed, characters whose flag bit is 0 are treated as traffic for other stations and are dropped. The first character whose flag bit is 1 is stored, and the hunt ends. Framing errors and queue overruns are held in sticky flags. Those flags and the receiver state can be read at the ports.

Top module: `mp_async_rx`

## Requirements
- R1: After reset the receiver is off, the queue is empty (level 0), the hunt is not armed, and both error flags read 0.
- R2: Command code 0x12 turns the receiver on and starts the search for a start bit. While the receiver is off, incoming frames are not stored. If 0x12 arrives while the receiver is already on, it changes nothing, and a character in progress still arrives intact.
- R3: Command code 0x13 turns the receiver off and discards any partly received character. Characters already in the queue and the queue level are left as they were.
- R4: A frame has this layout on the line: a low start bit, 8 data bits LSB first, one flag bit, and a high stop bit. Each bit lasts 16 sample-enables. A stored character appears on rd_data_o (data) and rd_mp_o (flag bit).
- R5: Command code 0x16 arms the hunt (mp_hunt_o = 1). While the hunt is armed, characters with flag bit 0 are not stored.
- R6: A character with flag bit 1 that arrives while the hunt is armed is stored, and the hunt ends. After that, characters with flag bit 0 are stored again.
- R7: A low pulse on the line that is shorter than half a bit is rejected as a start bit, and no character results.
- R8: A character with a low stop bit is not stored, and frame_err_o is set. The flag stays set while later characters are received.
- R9: The queue holds 4 characters in arrival order, and its head is always visible on the outputs. rd_en_i removes the head. rd_en_i on an empty queue has no effect.
- R10: A character that arrives while the queue is full is dropped, overrun_o is set and stays set, and the queued characters are kept.
- R11: Command codes other than 0x12, 0x13 and 0x16 change neither the receiver state nor the hunt, and they do not disturb a character in progress.
- R12: Command 0x13 clears frame_err_o and overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Sample enable at 16x bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| cmd_valid_i | input | 1 | Single-cycle command strobe |
| cmd_code_i | input | 8 | Command code |
| rd_en_i | input | 1 | Pop queue head |
| rd_data_o | output | 8 | Data of queue head |
| rd_mp_o | output | 1 | Flag bit of queue head |
| rd_empty_o | output | 1 | Queue empty |
| rd_level_o | output | 3 | Characters in queue |
| rx_on_o | output | 1 | Receiver enabled |
| mp_hunt_o | output | 1 | Address hunt armed |
| frame_err_o | output | 1 | Sticky framing error |
| overrun_o | output | 1 | Sticky overrun |

## Verification
Several commands are issued in the middle of a character. A repeated enable or an unknown code at that point must leave the character intact; a design that restarted the bit engine would lose or corrupt it. A disable at that point must discard only the partial character; a design that also reset the queue would lose earlier data. The hunt sequence sends a flag-0 character, then a flag-1 character, then another flag-0 character, which catches a hunt that never disarms or one that drops the addressing character. Short line glitches, a low stop bit and a fifth character into a full queue check that false starts, bad frames and overflow leave the queue contents unchanged.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  localparam int DATA_BITS = 8;

  localparam logic [7:0] CMD_RX_ON   = 8'h12;
  localparam logic [7:0] CMD_RX_OFF  = 8'h13;
  localparam logic [7:0] CMD_MP_HUNT = 8'h16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MP,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic                 mp;
    logic [DATA_BITS-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/rx_cmd_ctrl.sv
module rx_cmd_ctrl
  import mp_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_code_i,
  input  logic       char_done_i,
  input  logic       char_ok_i,
  input  logic       char_mp_i,
  output logic       rx_on_o,
  output logic       hunt_o,
  output logic       flag_clr_o
);
  logic is_on, is_off, is_hunt;
  assign is_on   = cmd_valid_i && (cmd_code_i == CMD_RX_ON);
  assign is_off  = cmd_valid_i && (cmd_code_i == CMD_RX_OFF);
  assign is_hunt = cmd_valid_i && (cmd_code_i == CMD_MP_HUNT);
  assign flag_clr_o = is_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_on_o <= 1'b0;
      hunt_o  <= 1'b0;
    end else begin
      if (is_off)      rx_on_o <= 1'b0;
      else if (is_on)  rx_on_o <= 1'b1;
      // a fresh arm wins over an address match in the same cycle
      if (is_hunt)     hunt_o <= 1'b1;
      else if (char_done_i && char_ok_i && char_mp_i) hunt_o <= 1'b0;
    end
  end

  a_r2_on_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_on_o && !is_off |=> rx_on_o);
  a_r6_hunt_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_o && char_done_i && char_ok_i && char_mp_i && !cmd_valid_i |=> !hunt_o);
  a_r11_unknown_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !is_on && !is_off && !is_hunt && !char_done_i
      |=> $stable(rx_on_o) && $stable(hunt_o));
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import mp_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  logic     rxd_i,
  output logic     done_o,
  output logic     stop_ok_o,
  output rx_char_t char_o
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  rxd_s;
  rx_state_e             state_q;
  logic [CW-1:0]         cnt_q;
  logic [IW-1:0]         idx_q;
  logic [DATA_BITS-1:0]  shreg_q;
  logic                  mp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_DEPTH-2:0], rxd_i};
  end
  assign rxd_s = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      mp_q      <= 1'b0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else if (!run_i) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      mp_q      <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rxd_s) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              state_q <= rxd_s ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              shreg_q <= {rxd_s, shreg_q[DATA_BITS-1:1]};
              if (idx_q == IW'(DATA_BITS - 1)) state_q <= ST_MP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_MP: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              mp_q    <= rxd_s;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q     <= '0;
              done_o    <= 1'b1;
              stop_ok_o <= rxd_s;
              state_q   <= ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign char_o = '{mp: mp_q, data: shreg_q};

  a_r3_off_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> state_q == ST_IDLE && shreg_q == '0 && !done_o);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             wdata_i,
  input  logic                         pop_i,
  output logic [WIDTH-1:0]             head_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [LW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= wdata_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r9_pop_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty_o && !push_i |=> level_o == $past(level_o) - 1'b1);
  a_r9_empty_pop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> empty_o);
endmodule

// File: rtl/mp_async_rx.sv
module mp_async_rx
  import mp_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick16_i,
  input  logic                              rxd_i,
  input  logic                              cmd_valid_i,
  input  logic [7:0]                        cmd_code_i,
  input  logic                              rd_en_i,
  output logic [DATA_BITS-1:0]              rd_data_o,
  output logic                              rd_mp_o,
  output logic                              rd_empty_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   rd_level_o,
  output logic                              rx_on_o,
  output logic                              mp_hunt_o,
  output logic                              frame_err_o,
  output logic                              overrun_o
);
  localparam int CHW = $bits(rx_char_t);

  logic     run, hunt, flag_clr;
  logic     done, stop_ok;
  rx_char_t rx_char, head;
  logic     keep, push, full;

  rx_cmd_ctrl u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .char_done_i (done),
    .char_ok_i   (stop_ok),
    .char_mp_i   (rx_char.mp),
    .rx_on_o     (run),
    .hunt_o      (hunt),
    .flag_clr_o  (flag_clr)
  );

  rx_bit_engine #(.OSR(OSR), .SYNC_DEPTH(SYNC_DEPTH)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick16_i),
    .rxd_i     (rxd_i),
    .done_o    (done),
    .stop_ok_o (stop_ok),
    .char_o    (rx_char)
  );

  // address filter: during a hunt only flag-1 characters pass
  assign keep = done && stop_ok && !(hunt && !rx_char.mp);
  assign push = keep && !full;

  rx_char_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (rx_char),
    .pop_i   (rd_en_i),
    .head_o  (head),
    .full_o  (full),
    .empty_o (rd_empty_o),
    .level_o (rd_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else if (flag_clr) begin
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (done && !stop_ok) frame_err_o <= 1'b1;
      if (keep && full)     overrun_o   <= 1'b1;
    end
  end

  assign rd_data_o = head.data;
  assign rd_mp_o   = head.mp;
  assign rx_on_o   = run;
  assign mp_hunt_o = hunt;

  a_r5_hunt_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt && done && !rx_char.mp |-> !push);
  a_r8_frame_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !stop_ok && !flag_clr |=> frame_err_o);
  a_r8_bad_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !stop_ok |-> !push);
  a_r10_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep && full && !flag_clr |=> overrun_o);
  a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr |=> !frame_err_o && !overrun_o);
endmodule

// File: tb/sim_mp_async_rx.sv
module sim_mp_async_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CYC    = 16 * TICK_DIV;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rxd = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_mp, rd_empty, rx_on, hunt, ferr, ovr;
  logic [2:0] level;

  int total = 0;
  int bad   = 0;
  int tick_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
  assign tick = (tick_cnt == 0);

  mp_async_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_mp_o(rd_mp), .rd_empty_o(rd_empty),
    .rd_level_o(level), .rx_on_o(rx_on), .mp_hunt_o(hunt),
    .frame_err_o(ferr), .overrun_o(ovr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reset_dut();
    rxd = 1'b1; cmd_valid = 1'b0; rd_en = 1'b0;
    rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
  endtask

  task automatic cmd(input logic [7:0] code);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_code = code;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    cycles(1);
  endtask

  // frame on the line; optional command issued at the start of bit cmd_bit
  task automatic send(input logic [7:0] d, input logic mp, input logic stop_hi,
                      input int cmd_bit, input logic [7:0] code);
    logic [10:0] bits;
    bits = {stop_hi, mp, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      if (i == 10 && !stop_hi) begin
        cycles(10 * TICK_DIV);
        rxd = 1'b1;
        cycles(BIT_CYC - 10 * TICK_DIV);
      end else if (i == cmd_bit) begin
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_code = code;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cycles(BIT_CYC - 2);
      end else begin
        cycles(BIT_CYC);
      end
    end
    rxd = 1'b1;
    cycles(BIT_CYC);
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] d, input logic mp);
    chk({tag, " empty"}, rd_empty, 0);
    chk({tag, " data"}, rd_data, d);
    chk({tag, " mp"}, rd_mp, mp);
    rd_en = 1'b1;
    cycles(1);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 rx_on", rx_on, 0);
    chk("R1 empty", rd_empty, 1);
    chk("R1 level", level, 0);
    chk("R1 hunt", hunt, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 ovr", ovr, 0);
  endtask

  task automatic t_off_and_basic();
    reset_dut();
    send(8'h6B, 1'b0, 1'b1, -1, 8'h00);
    chk("R2 off not stored", level, 0);
    cmd(8'h12);
    chk("R2 rx_on", rx_on, 1);
    send(8'hA5, 1'b0, 1'b1, -1, 8'h00);
    send(8'h3C, 1'b1, 1'b1, -1, 8'h00);
    chk("R4 level", level, 2);
    pop_chk("R4 first", 8'hA5, 1'b0);
    pop_chk("R4 second", 8'h3C, 1'b1);
    chk("R9 empty after", rd_empty, 1);
    rd_en = 1'b1; cycles(1); rd_en = 1'b0;
    chk("R9 pop empty level", level, 0);
    send(8'h01, 1'b0, 1'b1, -1, 8'h00);
    chk("R9 after empty pop level", level, 1);
    pop_chk("R9 after empty pop", 8'h01, 1'b0);
  endtask

  task automatic t_mid_cmds();
    reset_dut();
    cmd(8'h12);
    send(8'hC3, 1'b1, 1'b1, 4, 8'h12);
    chk("R2 reenable rx_on", rx_on, 1);
    pop_chk("R2 reenable char", 8'hC3, 1'b1);
    send(8'h5E, 1'b0, 1'b1, 6, 8'h14);
    send(8'h9D, 1'b0, 1'b1, 3, 8'hFF);
    chk("R11 rx_on", rx_on, 1);
    chk("R11 hunt", hunt, 0);
    chk("R11 level", level, 2);
    pop_chk("R11 char a", 8'h5E, 1'b0);
    pop_chk("R11 char b", 8'h9D, 1'b0);
  endtask

  task automatic t_disable();
    reset_dut();
    cmd(8'h12);
    send(8'h5A, 1'b1, 1'b1, -1, 8'h00);
    send(8'h81, 1'b1, 1'b1, 5, 8'h13);
    chk("R3 rx_on", rx_on, 0);
    chk("R3 level kept", level, 1);
    chk("R3 head kept", rd_data, 8'h5A);
    cmd(8'h12);
    send(8'h42, 1'b0, 1'b1, -1, 8'h00);
    chk("R3 level", level, 2);
    pop_chk("R3 old", 8'h5A, 1'b1);
    pop_chk("R3 new", 8'h42, 1'b0);
  endtask

  task automatic t_hunt();
    reset_dut();
    cmd(8'h12);
    cmd(8'h16);
    chk("R5 armed", hunt, 1);
    send(8'h11, 1'b0, 1'b1, -1, 8'h00);
    chk("R5 dropped", level, 0);
    chk("R5 still armed", hunt, 1);
    send(8'h22, 1'b1, 1'b1, -1, 8'h00);
    chk("R6 stored", level, 1);
    chk("R6 disarmed", hunt, 0);
    send(8'h33, 1'b0, 1'b1, -1, 8'h00);
    chk("R6 later stored", level, 2);
    pop_chk("R6 addr", 8'h22, 1'b1);
    pop_chk("R6 data", 8'h33, 1'b0);
  endtask

  task automatic t_false_start();
    reset_dut();
    cmd(8'h12);
    rxd = 1'b0;
    cycles(4 * TICK_DIV);
    rxd = 1'b1;
    cycles(3 * BIT_CYC);
    chk("R7 glitch", level, 0);
    send(8'h96, 1'b0, 1'b1, -1, 8'h00);
    pop_chk("R7 next frame", 8'h96, 1'b0);
  endtask

  task automatic t_frame_err();
    reset_dut();
    cmd(8'h12);
    send(8'h77, 1'b1, 1'b0, -1, 8'h00);
    cycles(2 * BIT_CYC);
    chk("R8 flag", ferr, 1);
    chk("R8 not stored", level, 0);
    send(8'h55, 1'b0, 1'b1, -1, 8'h00);
    chk("R8 sticky", ferr, 1);
    chk("R8 next stored", level, 1);
    cmd(8'h13);
    chk("R12 ferr cleared", ferr, 0);
    chk("R12 level kept", level, 1);
  endtask

  task automatic t_overrun();
    reset_dut();
    cmd(8'h12);
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), 1'(i), 1'b1, -1, 8'h00);
    chk("R10 level", level, 4);
    chk("R10 flag", ovr, 1);
    for (int i = 0; i < 4; i++) pop_chk("R10 order", 8'h10 + 8'(i), 1'(i));
    chk("R10 drained", rd_empty, 1);
    chk("R10 sticky", ovr, 1);
    cmd(8'h13);
    chk("R12 ovr cleared", ovr, 0);
  endtask

  initial begin
    t_reset();
    t_off_and_basic();
    t_mid_cmds();
    t_disable();
    t_hunt();
    t_false_start();
    t_frame_err();
    t_overrun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule